// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs processor-style bus cycles on a shared address/data bus. A requester presents a word address, write data, a read/write flag, a memory/IO flag, two byte enables and a two-bit segment status code. The block then steps through the bus states T1, T2 and T3, then zero or more wait states, then T4. It drives the address-latch strobe, the read and write strobes, the transceiver enable and direction lines, the memory/IO line and the high-byte enable. For a read it returns the data it samples from the bus.

Each bus state lasts one clock period and begins on a rising edge. A few events fall in the middle of a state. These are the late start of the transceiver enable on reads, the end of that enable in T4, and the rise and fall of the hold acknowledge. Registers on the falling edge produce these events. Every bus and control output has an output-enable, so the pads can float while another master owns the bus. The latch strobe is always driven.

A second master asks for the bus with `hold`. At a cycle boundary the block gives it the bus and raises `hlda`. Any request that arrives meanwhile waits and starts once `hlda` has dropped.

Top module: `mbus_cycle_seq`

## Requirements
- R1: In T1 the shared bus is driven with {word address[14:0], A0}. The upper lines carry word address[18:15] for memory cycles and zero for IO cycles. `ale` is high for exactly the T1 period and is low at all other times.
- R2: After T1 the upper lines carry the status {2'b00, segment code}. In T2, T3, wait states and T4 the shared bus carries the write data for a write cycle. For a read cycle the shared bus is released (`ad_oe` low).
- R3: `rd_n` is low only during T2, T3 and wait states of a read cycle. `wr_n` is low only during the same states of a write cycle. The two are never low together.
- R4: On a read, `den_n` goes low at the falling edge inside T2 and returns high at the falling edge inside T4.
- R5: On a write, `den_n` goes low at the start of T2 and returns high at the falling edge inside T4.
- R6: `dtr_n` is 1 for writes and 0 for reads. `mio_n` is 1 for memory and 0 for IO. Both are set at the start of T1 and hold through T4.
- R7: The pair {`bhe_n`, A0} comes from the byte enables {be[1], be[0]} as {~be[1], ~be[0]}. This gives 00 = whole word, 01 = upper byte at an odd address, 10 = lower byte at an even address, 11 = no byte.
- R8: `ready` is sampled on the rising edge that ends T3 and on the edge that ends each wait state. Low inserts another wait state. High moves to T4. On a read, the bus data at that edge appears on `rd_data`, and `rd_valid` is high for the one T4 period.
- R9: `hold` sampled high on a rising edge in idle or at the end of T4 releases the bus. `hlda` rises at the next falling edge. While `hlda` is high, `ad_oe` and `ctl_oe` are low and `ale` stays low but driven.
- R10: When `hold` is sampled low on a rising edge during a hold, `hlda` falls at the next falling edge.
- R11: No request is accepted while `hold` or `hlda` is high. A request held during a hold begins T1 on the first rising edge after `hlda` has fallen.
- R12: A request that is valid during T4 starts its T1 on the very next clock, with no idle state between.
- R13: After reset the block is idle: all strobes are inactive, `hlda` is low, the shared bus is released and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period per bus state |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this rising edge |
| req_waddr | input | AW-1 | Word address (address bits AW-1..1) |
| req_wdata | input | DW | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory, 0 = IO |
| req_be | input | 2 | Byte enables, bit 1 = high byte |
| req_seg | input | 2 | Segment status code shown after T1 |
| rd_valid | output | 1 | Read data valid (T4 of a read) |
| rd_data | output | DW | Captured read data |
| ad_out | output | DW | Shared address/data bus, outgoing value |
| ad_in | input | DW | Shared address/data bus, incoming value |
| ad_oe | output | 1 | Drive enable for the shared bus |
| ahi_out | output | AW-DW | Upper address / status lines |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Transceiver enable, active low |
| dtr_n | output | 1 | Transceiver direction: 1 transmit, 0 receive |
| mio_n | output | 1 | 1 memory, 0 IO |
| bhe_n | output | 1 | High byte enable, active low |
| ctl_oe | output | 1 | Drive enable for control, status and upper lines |
| ready | input | 1 | Access-complete from the target |
| hold | input | 1 | Bus release request from another master |
| hlda | output | 1 | Bus release acknowledge |

## Verification
The properties assume that `hold`, `ready` and the request fields are already synchronous to `clk`. Those inputs change only away from the rising edge, and a request stays unchanged while it waits for `req_ready`. The stimulus drives every input one nanosecond after a rising edge and holds the request until the edge that accepts it. It samples once before and once after the falling edge, so each mid-state transition is seen on its own side. The stimulus never drops `hold` in the cycle it is raised. Because of this, the hold-acknowledge check can rely on `hold` having been high at the edge before.

// File: rtl/mbus_pkg.sv
`timescale 1ns/100ps
package mbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_TW   = 3'd4,
        ST_T4   = 3'd5,
        ST_HOLD = 3'd6
    } bus_st_e;

    // States in which a read or write strobe is active
    function automatic logic strobe_phase(input bus_st_e s);
        return (s == ST_T2) || (s == ST_T3) || (s == ST_TW);
    endfunction

endpackage

// File: rtl/mbus_fsm.sv
`timescale 1ns/100ps
module mbus_fsm
    import mbus_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [AW-2:0]  req_waddr,
    input  logic [DW-1:0]  req_wdata,
    input  logic           req_write,
    input  logic           req_mem,
    input  logic [1:0]     req_be,
    input  logic [1:0]     req_seg,
    input  logic           hold,
    input  logic           ready,
    input  logic           hlda,
    input  logic [DW-1:0]  ad_in,
    output logic           req_ready,
    output bus_st_e        st,
    output logic           cyc_wr,
    output logic           cyc_mem,
    output logic [1:0]     cyc_be,
    output logic [1:0]     cyc_seg,
    output logic [AW-2:0]  cyc_addr,
    output logic [DW-1:0]  cyc_wdata,
    output logic [DW-1:0]  rd_data,
    output logic           rd_valid
);
    localparam int WAW = AW - 1;

    typedef struct packed {
        bus_st_e        st;
        logic           wr;
        logic           mem;
        logic [1:0]     be;
        logic [1:0]     seg;
        logic [WAW-1:0] addr;
        logic [DW-1:0]  wdata;
        logic [DW-1:0]  rdata;
        logic           rvalid;
    } fsm_s;

    fsm_s s_d, s_q;
    logic boundary;

    assign boundary  = (s_q.st == ST_IDLE) || (s_q.st == ST_T4);
    assign req_ready = boundary && !hold && !hlda;

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = 1'b0;
        unique case (s_q.st)
            ST_IDLE, ST_T4: begin
                if (hold) begin
                    s_d.st = ST_HOLD;
                end else if (req_valid && req_ready) begin
                    s_d.st    = ST_T1;
                    s_d.wr    = req_write;
                    s_d.mem   = req_mem;
                    s_d.be    = req_be;
                    s_d.seg   = req_seg;
                    s_d.addr  = req_waddr;
                    s_d.wdata = req_wdata;
                end else begin
                    s_d.st = ST_IDLE;
                end
            end
            ST_T1: s_d.st = ST_T2;
            ST_T2: s_d.st = ST_T3;
            ST_T3, ST_TW: begin
                if (ready) begin
                    s_d.st = ST_T4;
                    if (!s_q.wr) begin
                        s_d.rdata  = ad_in;
                        s_d.rvalid = 1'b1;
                    end
                end else begin
                    s_d.st = ST_TW;
                end
            end
            ST_HOLD: if (!hold) s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign st        = s_q.st;
    assign cyc_wr    = s_q.wr;
    assign cyc_mem   = s_q.mem;
    assign cyc_be    = s_q.be;
    assign cyc_seg   = s_q.seg;
    assign cyc_addr  = s_q.addr;
    assign cyc_wdata = s_q.wdata;
    assign rd_data   = s_q.rdata;
    assign rd_valid  = s_q.rvalid;

endmodule

// File: rtl/mbus_halfedge.sv
`timescale 1ns/100ps
module mbus_halfedge
    import mbus_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  bus_st_e st,
    output logic    den_mid,
    output logic    hlda
);
    typedef struct packed {
        logic den_mid;
        logic hlda;
    } half_s;

    half_s h_d, h_q;

    always_comb begin
        h_d.den_mid = strobe_phase(st);
        h_d.hlda    = (st == ST_HOLD);
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign den_mid = h_q.den_mid;
    assign hlda    = h_q.hlda;

endmodule

// File: rtl/mbus_cycle_seq.sv
`timescale 1ns/100ps
module mbus_cycle_seq
    import mbus_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AW-2:0]     req_waddr,
    input  logic [DW-1:0]     req_wdata,
    input  logic              req_write,
    input  logic              req_mem,
    input  logic [1:0]        req_be,
    input  logic [1:0]        req_seg,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic [DW-1:0]     ad_out,
    input  logic [DW-1:0]     ad_in,
    output logic              ad_oe,
    output logic [AW-DW-1:0]  ahi_out,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              den_n,
    output logic              dtr_n,
    output logic              mio_n,
    output logic              bhe_n,
    output logic              ctl_oe,
    input  logic              ready,
    input  logic              hold,
    output logic              hlda
);
    localparam int WAW = AW - 1;
    localparam int HAW = AW - DW;

    bus_st_e          st;
    logic             cyc_wr, cyc_mem, den_mid, data_ph;
    logic [1:0]       cyc_be, cyc_seg;
    logic [WAW-1:0]   cyc_addr;
    logic [DW-1:0]    cyc_wdata;

    mbus_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_waddr (req_waddr),
        .req_wdata (req_wdata),
        .req_write (req_write),
        .req_mem   (req_mem),
        .req_be    (req_be),
        .req_seg   (req_seg),
        .hold      (hold),
        .ready     (ready),
        .hlda      (hlda),
        .ad_in     (ad_in),
        .req_ready (req_ready),
        .st        (st),
        .cyc_wr    (cyc_wr),
        .cyc_mem   (cyc_mem),
        .cyc_be    (cyc_be),
        .cyc_seg   (cyc_seg),
        .cyc_addr  (cyc_addr),
        .cyc_wdata (cyc_wdata),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    mbus_halfedge u_half (
        .clk     (clk),
        .rst_n   (rst_n),
        .st      (st),
        .den_mid (den_mid),
        .hlda    (hlda)
    );

    always_comb begin
        data_ph = strobe_phase(st);
        ale     = (st == ST_T1);
        rd_n    = !(data_ph && !cyc_wr);
        wr_n    = !(data_ph && cyc_wr);
        // writes open the transceiver at T2 start, reads wait for mid-T2
        den_n   = !((data_ph && cyc_wr) || den_mid);
        dtr_n   = cyc_wr;
        mio_n   = cyc_mem;
        bhe_n   = ~cyc_be[1];
        ctl_oe  = !hlda;
        ad_oe   = !hlda && ((st == ST_T1) ||
                            (cyc_wr && (data_ph || st == ST_T4)));
        if (st == ST_T1) begin
            ad_out  = {cyc_addr[DW-2:0], ~cyc_be[0]};
            ahi_out = cyc_mem ? cyc_addr[WAW-1:DW-1] : '0;
        end else begin
            ad_out  = cyc_wdata;
            ahi_out = HAW'(cyc_seg);
        end
    end

endmodule

// File: rtl/mbus_cycle_seq_chk.sv
`timescale 1ns/100ps
module mbus_cycle_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic rd_valid,
    input logic ad_oe,
    input logic ale,
    input logic rd_n,
    input logic wr_n,
    input logic den_n,
    input logic dtr_n,
    input logic mio_n,
    input logic ctl_oe,
    input logic hold,
    input logic hlda
);
    p_ale_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    p_rd_den_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !den_n);

    p_wr_den_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> !den_n);

    p_dir_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> ($stable(dtr_n) && $stable(mio_n)));

    p_rvalid_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (!dtr_n && rd_n));

    p_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> (!ctl_oe && !ad_oe && !ale));

    p_hold_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> $past(hold));

    p_no_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> (!hlda && !hold));

endmodule

bind mbus_cycle_seq mbus_cycle_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .ad_oe     (ad_oe),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .den_n     (den_n),
    .dtr_n     (dtr_n),
    .mio_n     (mio_n),
    .ctl_oe    (ctl_oe),
    .hold      (hold),
    .hlda      (hlda)
);

// File: tb/mbus_cycle_seq_tb.sv
`timescale 1ns/100ps
module mbus_cycle_seq_tb;
    localparam int AW = 20;
    localparam int DW = 16;

    typedef struct packed {
        logic        wr;
        logic        mem;
        logic [1:0]  be;
        logic [1:0]  seg;
        logic [18:0] waddr;
        logic [15:0] wdata;
        logic [15:0] rdata;
        logic [1:0]  waits;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b1, 2'b11, 2'd1, 19'h5A5A5, 16'h0000, 16'hBEEF, 2'd0},
        '{1'b1, 1'b1, 2'b01, 2'd2, 19'h12345, 16'hC0DE, 16'h0000, 2'd2},
        '{1'b0, 1'b0, 2'b10, 2'd0, 19'h00F0F, 16'h0000, 16'h1234, 2'd1},
        '{1'b1, 1'b0, 2'b11, 2'd3, 19'h7FFFF, 16'hA55A, 16'h0000, 2'd0},
        '{1'b0, 1'b1, 2'b00, 2'd3, 19'h40001, 16'h0000, 16'h0F0F, 2'd3},
        '{1'b1, 1'b1, 2'b10, 2'd1, 19'h2AAAA, 16'h5555, 16'h0000, 2'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b0;
    logic [AW-2:0] req_waddr = '0;
    logic [DW-1:0] req_wdata = '0, ad_in = '0;
    logic [1:0] req_be = '0, req_seg = '0;
    logic ready = 1'b1, hold = 1'b0;
    logic req_ready, rd_valid, ad_oe, ale, rd_n, wr_n, den_n, dtr_n, mio_n;
    logic bhe_n, ctl_oe, hlda;
    logic [DW-1:0] rd_data, ad_out;
    logic [AW-DW-1:0] ahi_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    mbus_cycle_seq #(.AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_waddr(req_waddr), .req_wdata(req_wdata), .req_write(req_write),
        .req_mem(req_mem), .req_be(req_be), .req_seg(req_seg),
        .rd_valid(rd_valid), .rd_data(rd_data), .ad_out(ad_out), .ad_in(ad_in),
        .ad_oe(ad_oe), .ahi_out(ahi_out), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .den_n(den_n), .dtr_n(dtr_n), .mio_n(mio_n), .bhe_n(bhe_n),
        .ctl_oe(ctl_oe), .ready(ready), .hold(hold), .hlda(hlda)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // early phase: 1 ns after a rising edge, before the falling edge
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // late phase: after the falling edge, before the next rising edge
    task automatic late();
        #2.5;
    endtask

    task automatic run_vec(input vec_t v);
        tick();
        req_write = v.wr; req_mem = v.mem; req_be = v.be; req_seg = v.seg;
        req_waddr = v.waddr; req_wdata = v.wdata; ad_in = v.rdata;
        ready = 1'b1; req_valid = 1'b1;
        tick(); // T1
        req_valid = 1'b0;
        chk("R1 ale in T1", ale, 1);
        chk("R1 bus drive T1", ad_oe, 1);
        chk("R1 low address", ad_out[15:1], v.waddr[14:0]);
        chk("R1 upper address", ahi_out, v.mem ? v.waddr[18:15] : 4'h0);
        chk("R7 bhe_n/A0", {bhe_n, ad_out[0]}, {~v.be[1], ~v.be[0]});
        chk("R6 dtr_n", dtr_n, v.wr);
        chk("R6 mio_n", mio_n, v.mem);
        chk("R3 strobes idle in T1", {rd_n, wr_n, den_n}, 3'b111);
        late();
        chk("R1 ale late T1", ale, 1);
        tick(); // T2
        chk("R1 ale low in T2", ale, 0);
        chk("R3 rd_n T2", rd_n, v.wr);
        chk("R3 wr_n T2", wr_n, !v.wr);
        chk(v.wr ? "R5 den_n T2 start" : "R4 den_n T2 start", den_n, !v.wr);
        chk("R2 bus drive T2", ad_oe, v.wr);
        chk("R2 status", ahi_out, {2'b00, v.seg});
        if (v.wr) chk("R2 write data", ad_out, v.wdata);
        late();
        chk(v.wr ? "R5 den_n mid T2" : "R4 den_n mid T2", den_n, 0);
        tick(); // T3
        chk("R3 strobe T3", {rd_n, wr_n}, {v.wr, !v.wr});
        ready = (v.waits == 0);
        for (int w = 0; w < int'(v.waits); w++) begin
            tick(); // TW
            chk("R8 strobe held in wait", {rd_n, wr_n, den_n}, {v.wr, !v.wr, 1'b0});
            ready = (w == int'(v.waits) - 1);
        end
        tick(); // T4
        ready = 1'b1;
        chk("R8 strobes off in T4", {rd_n, wr_n}, 2'b11);
        chk(v.wr ? "R5 den_n early T4" : "R4 den_n early T4", den_n, 0);
        chk("R8 rd_valid", rd_valid, !v.wr);
        if (!v.wr) chk("R8 read data", rd_data, v.rdata);
        chk("R6 dtr_n held T4", dtr_n, v.wr);
        late();
        chk(v.wr ? "R5 den_n mid T4" : "R4 den_n mid T4", den_n, 1);
        tick(); // idle
        chk("R1 ale idle", ale, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        chk("R13 reset strobes", {ale, rd_n, wr_n, den_n}, 4'b0111);
        chk("R13 reset hlda", hlda, 0);
        chk("R13 reset bus released", ad_oe, 0);
        chk("R13 reset ready", req_ready, 1);

        for (int i = 0; i < 6; i++) run_vec(VECS[i]);

        // hold with a queued request
        tick();
        hold = 1'b1;
        tick(); // hold state, first half
        chk("R9 hlda before mid", hlda, 0);
        req_write = 1'b0; req_mem = 1'b1; req_be = 2'b11; req_waddr = 19'h01111;
        req_valid = 1'b1;
        late();
        chk("R9 hlda mid", hlda, 1);
        chk("R9 float", {ad_oe, ctl_oe}, 2'b00);
        chk("R9 ale driven low", ale, 0);
        chk("R11 no accept in hold", req_ready, 0);
        tick();
        tick();
        chk("R11 queued waits", ale, 0);
        hold = 1'b0;
        tick(); // idle, hlda still up
        chk("R10 hlda until mid", hlda, 1);
        chk("R11 blocked while hlda", req_ready, 0);
        late();
        chk("R10 hlda dropped", hlda, 0);
        chk("R11 float ended", ctl_oe, 1);
        tick(); // T1 of queued request
        chk("R11 queued request starts", ale, 1);
        req_valid = 1'b0;
        tick(); tick(); tick(); tick();
        chk("R11 cycle done", {ale, rd_n, den_n}, 3'b011);

        // back-to-back requests
        req_write = 1'b1; req_wdata = 16'h3C3C; req_valid = 1'b1;
        tick(); // T1
        tick(); tick(); // T2, T3
        tick(); // T4
        chk("R12 accept in T4", req_ready, 1);
        tick(); // T1 again
        chk("R12 no idle between", ale, 1);
        req_valid = 1'b0;
        tick(); tick(); tick(); tick();
        chk("R12 second ends", {ale, wr_n}, 2'b01);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule